// File: doc/BRIEF.md
# Flash Data-Polling Status Responder

This block stands in for the read side of a small byte-wide flash array while an automatic program or chip-erase operation runs. A host issues a one-cycle "program byte" or "chip erase" strobe. A down-counter then takes the place of the internal algorithm for a fixed number of cycles, and `busy` stays high for that time. While the operation runs, a read does not reach the array. It returns a status byte. The top bit of that byte depends on the operation: it is the complement of the top bit of the byte being programmed, or zero during an erase. The lower seven bits are zero.

When the operation finishes, the array is updated and reads return stored data again. Programming can only clear bits. Erasing sets every byte to all ones. Software therefore knows an operation has finished when the status bit reaches its final value: the true top bit of the programmed byte, or one after an erase. A fault seen during the operation moves the block into a failed state. In that state the status bit stays at its in-progress value, the array is left alone, and `busy` stays high. Only a clear-fault strobe or a system reset leaves the failed state.

Top module: `flash_poll_responder`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0x00 and every array byte reads 0xFF.
- R2: A program strobe accepted while idle holds `busy` high for exactly PROG_CYCLES cycles. An erase strobe holds it high for exactly ERASE_CYCLES cycles. `busy` rises in the cycle after the strobe.
- R3: During a program operation, any read returns a byte whose bit 7 is the inverse of bit 7 of the write data and whose bits 6..0 are 0, whatever the read address.
- R4: When a program operation completes, the addressed byte becomes the old byte AND the write data. No other byte changes.
- R5: During a chip erase, any read returns 0x00.
- R6: When a chip erase completes, every byte reads 0xFF.
- R7: Program and erase strobes that arrive while `busy` is high are ignored. They change neither the array nor the length of the running operation.
- R8: A `fault` sampled high during an operation enters the failed state. `busy` stays high, reads keep returning the in-progress status byte, and the array is not changed by the failed operation. A `fault` outside an operation has no effect.
- R9: `clear_fault` in the failed state returns the block to idle, so `busy` is 0 in the next cycle. `clear_fault` while idle has no effect.
- R10: If program and erase strobes arrive together while idle, the program operation is started.
- R11: `rd_data` is registered. It reflects a read one cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address for reads and program strobes |
| wr_data | input | 8 | Byte to program |
| rd_en | input | 1 | Read strobe |
| prog_go | input | 1 | Start program-byte operation |
| erase_go | input | 1 | Start chip-erase operation |
| clear_fault | input | 1 | Leave the failed state |
| fault | input | 1 | Operation failure indication |
| rd_data | output | 8 | Registered read data or status byte |
| busy | output | 1 | Operation running or failed |

## Verification
If the operation-type register were wrong, the status byte would show the wrong top bit on the first read after the strobe, one cycle after `rd_en`. A wrong busy counter would show up as a `busy` pulse of the wrong length, which is visible as soon as `busy` falls. A failed state that drops or leaks would either release `busy` without `clear_fault`, or change the array. The array change shows on the next read of the targeted byte after the block returns to idle.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FAIL = 2'd2
  } seq_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  // Flash cells can only be cleared by programming.
  function automatic logic [BYTE_W-1:0] program_merge(
      input logic [BYTE_W-1:0] old_byte,
      input logic [BYTE_W-1:0] new_byte);
    return old_byte & new_byte;
  endfunction

  // In-progress value of the polling bit.
  function automatic logic poll_value(input op_kind_e kind, input logic msb);
    return (kind == OP_PROGRAM) ? ~msb : 1'b0;
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic pbit);
    return {pbit, {(BYTE_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/fpr_sequencer.sv
module fpr_sequencer
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic              clear_fault,
  input  logic              fault,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output seq_state_e        state,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [BYTE_W-1:0] tgt_data,
  output logic              start_evt,
  output logic              done_evt,
  output logic              fault_evt,
  output logic              clear_evt
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CYC   = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  assign start_evt = (state == SEQ_IDLE) && (prog_go || erase_go);
  assign fault_evt = (state == SEQ_RUN) && fault;
  assign done_evt  = (state == SEQ_RUN) && !fault && (remain_q == LAST_CYC);
  assign clear_evt = (state == SEQ_FAIL) && clear_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      op_kind  <= OP_PROGRAM;
      remain_q <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_evt) begin
            state    <= SEQ_RUN;
            op_kind  <= prog_go ? OP_PROGRAM : OP_ERASE;
            remain_q <= prog_go ? PROG_LOAD : ERASE_LOAD;
            tgt_addr <= addr;
            tgt_data <= wr_data;
          end
        end
        SEQ_RUN: begin
          if (fault_evt)     state <= SEQ_FAIL;
          else if (done_evt) state <= SEQ_IDLE;
          else               remain_q <= remain_q - LAST_CYC;
        end
        SEQ_FAIL: begin
          if (clear_evt) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpr_array.sv
module fpr_array
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prog,
  input  logic              wr_erase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [BYTE_W-1:0] ERASED = {BYTE_W{1'b1}};

  logic [DEPTH-1:0][BYTE_W-1:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [BYTE_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   cell_q <= ERASED;
      else if (wr_erase)                            cell_q <= ERASED;
      else if (wr_prog && wr_addr == ADDR_W'(i))    cell_q <= program_merge(cell_q, wr_byte);
    end
    assign cells[i] = cell_q;
  end

  assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/fpr_read_port.sv
module fpr_read_port
  import flash_poll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              show_status,
  input  logic              poll_bit,
  input  logic [BYTE_W-1:0] array_byte,
  output logic [BYTE_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_en)   rd_data <= show_status ? status_byte(poll_bit) : array_byte;
  end
endmodule

// File: rtl/flash_poll_responder.sv
module flash_poll_responder
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic              clear_fault,
  input  logic              fault,
  output logic [7:0]        rd_data,
  output logic              busy
);
  seq_state_e        state;
  op_kind_e          op_kind;
  logic [ADDR_W-1:0] tgt_addr;
  logic [BYTE_W-1:0] tgt_data;
  logic              start_evt, done_evt, fault_evt, clear_evt;
  logic              in_fail;
  logic              poll_bit;
  logic              commit_prog, commit_erase;
  logic [BYTE_W-1:0] array_byte;

  fpr_sequencer #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .clear_fault(clear_fault), .fault(fault), .addr(addr), .wr_data(wr_data),
    .state(state), .op_kind(op_kind), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .start_evt(start_evt), .done_evt(done_evt), .fault_evt(fault_evt),
    .clear_evt(clear_evt)
  );

  assign busy         = (state != SEQ_IDLE);
  assign in_fail      = (state == SEQ_FAIL);
  assign poll_bit     = poll_value(op_kind, tgt_data[BYTE_W-1]);
  assign commit_prog  = done_evt && (op_kind == OP_PROGRAM);
  assign commit_erase = done_evt && (op_kind == OP_ERASE);

  fpr_array #(.ADDR_W(ADDR_W)) array_i (
    .clk(clk), .rst_n(rst_n), .wr_prog(commit_prog), .wr_erase(commit_erase),
    .wr_addr(tgt_addr), .wr_byte(tgt_data), .rd_addr(addr), .rd_byte(array_byte)
  );

  fpr_read_port read_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .show_status(busy),
    .poll_bit(poll_bit), .array_byte(array_byte), .rd_data(rd_data)
  );
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker #(
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       prog_go,
  input logic [7:0] wr_data,
  input logic       clear_fault,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       in_fail,
  input logic       start_evt,
  input logic       done_evt,
  input logic       fault_evt,
  input logic       clear_evt
);
  logic [31:0] ck_cnt, ck_lim;
  logic        ck_prog, ck_msb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_cnt <= '0; ck_lim <= '0; ck_prog <= 1'b0; ck_msb <= 1'b0;
    end else if (start_evt) begin
      ck_cnt  <= '0;
      ck_lim  <= prog_go ? 32'(PROG_CYCLES) : 32'(ERASE_CYCLES);
      ck_prog <= prog_go;
      ck_msb  <= wr_data[7];
    end else if (busy) begin
      ck_cnt <= ck_cnt + 32'd1;
    end
  end

  // R2: a completed operation lasted its configured number of cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && ck_cnt == ck_lim));

  // R3: status during a program run
  p_poll_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && ck_prog) |=> (rd_data == {~ck_msb, 7'b0}));

  // R5: status during an erase run
  p_poll_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && !ck_prog) |=> (rd_data == 8'h00));

  // R7: a running operation is not cut short by new strobes
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt && !clear_evt) |=> busy);

  // R8: the failed state keeps busy high until cleared
  p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt || (in_fail && !clear_fault)) |=> (busy && in_fail));

  // R9: clearing the fault frees the block
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !busy);

  // R11: read data holds without a read strobe
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind flash_poll_responder fpr_checker #(
  .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .prog_go(prog_go), .wr_data(wr_data),
  .clear_fault(clear_fault), .rd_data(rd_data), .busy(busy), .in_fail(in_fail),
  .start_evt(start_evt), .done_evt(done_evt), .fault_evt(fault_evt),
  .clear_evt(clear_evt)
);

// File: tb/flash_poll_responder_tb_top.sv
`timescale 1ns/1ps
module flash_poll_responder_tb_top;
  localparam int AW    = 4;
  localparam int PROG  = 6;
  localparam int ERASE = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0, prog_go = 1'b0, erase_go = 1'b0;
  logic          clear_fault = 1'b0, fault = 1'b0;
  logic [7:0]    rd_data;
  logic          busy;

  always #10 clk = ~clk;

  flash_poll_responder #(.ADDR_W(AW), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .rd_en(rd_en),
    .prog_go(prog_go), .erase_go(erase_go), .clear_fault(clear_fault),
    .fault(fault), .rd_data(rd_data), .busy(busy)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  logic rd_q = 1'b0;
  logic [7:0] model [16];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the read issued at the previous edge.
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_prog(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; prog_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0;
  endtask

  task automatic pulse_erase();
    erase_go = 1'b1;
    @(negedge clk);
    erase_go = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  int watch = 0;
  always @(posedge clk) begin
    watch++;
    if (watch > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000", watch);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
    do_read(4'd3, 8'hFF, "R1 erased after reset");
    do_read(4'd15, 8'hFF, "R1 erased after reset top");

    // R3/R4: program 0x25 at 3, poll bit = ~0 -> 0x80
    pulse_prog(4'd3, 8'h25);
    check(busy == 1'b1, "R2 busy rises", busy, 1);
    do_read(4'd3, 8'h80, "R3 poll on target");
    do_read(4'd5, 8'h80, "R3 poll on other address");
    wait_idle(n);
    model[3] = model[3] & 8'h25;
    do_read(4'd3, model[3], "R4 programmed byte");

    // R2/R4: program 0x0F, measure length, bit-clearing
    pulse_prog(4'd3, 8'h0F);
    wait_idle(n);
    check(n == PROG, "R2 program length", n, PROG);
    model[3] = model[3] & 8'h0F;
    do_read(4'd3, 8'h05, "R4 only clears bits");
    do_read(4'd4, 8'hFF, "R4 neighbour unchanged");

    // R3: bit7 of written byte is 1 -> poll 0x00
    pulse_prog(4'd7, 8'hC3);
    do_read(4'd7, 8'h00, "R3 poll with msb set");
    // R7: strobes while busy are ignored
    addr = 4'd9; wr_data = 8'h00; prog_go = 1'b1; erase_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0; erase_go = 1'b0;
    wait_idle(n);
    check(n == PROG - 2, "R7 length unaffected", n, PROG - 2);
    model[7] = 8'hC3;
    do_read(4'd9, 8'hFF, "R7 ignored program");
    do_read(4'd7, 8'hC3, "R7 no erase happened");

    // R10: both strobes while idle -> program wins
    addr = 4'd2; wr_data = 8'h5A; prog_go = 1'b1; erase_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0; erase_go = 1'b0;
    wait_idle(n);
    check(n == PROG, "R10 program length chosen", n, PROG);
    model[2] = 8'h5A;
    do_read(4'd2, 8'h5A, "R10 program applied");
    do_read(4'd7, 8'hC3, "R10 no erase");

    // R5/R6: erase
    pulse_erase();
    do_read(4'd5, 8'h00, "R5 poll on erased byte");
    do_read(4'd2, 8'h00, "R5 poll on written byte");
    wait_idle(n);
    check(n == ERASE - 2, "R2 erase length", n, ERASE - 2);
    for (int i = 0; i < 16; i++) model[i] = 8'hFF;
    do_read(4'd2, 8'hFF, "R6 erased 2");
    do_read(4'd3, 8'hFF, "R6 erased 3");
    do_read(4'd7, 8'hFF, "R6 erased 7");

    // R8/R9: fault during program
    pulse_prog(4'd2, 8'h12);
    @(negedge clk);
    fault = 1'b1; @(negedge clk); fault = 1'b0;
    repeat (PROG + 3) @(negedge clk);
    check(busy == 1'b1, "R8 busy held after program fault", busy, 1);
    do_read(4'd2, 8'h80, "R8 frozen program poll");
    clear_fault = 1'b1; @(negedge clk); clear_fault = 1'b0;
    check(busy == 1'b0, "R9 clear returns idle", busy, 0);
    do_read(4'd2, 8'hFF, "R8 array untouched by failed program");

    // R8: fault during erase
    pulse_prog(4'd1, 8'h3C);
    wait_idle(n);
    pulse_erase();
    fault = 1'b1; @(negedge clk); fault = 1'b0;
    repeat (ERASE + 3) @(negedge clk);
    check(busy == 1'b1, "R8 busy held after erase fault", busy, 1);
    do_read(4'd1, 8'h00, "R8 frozen erase poll");
    clear_fault = 1'b1; @(negedge clk); clear_fault = 1'b0;
    check(busy == 1'b0, "R9 clear after erase fault", busy, 0);
    do_read(4'd1, 8'h3C, "R8 array untouched by failed erase");

    // R8/R9: fault and clear while idle have no effect
    fault = 1'b1; clear_fault = 1'b1; @(negedge clk);
    fault = 1'b0; clear_fault = 1'b0;
    check(busy == 1'b0, "R9 idle strobes no effect", busy, 0);
    do_read(4'd1, 8'h3C, "R8 idle fault no effect");

    // R11: hold without read strobe
    addr = 4'd6;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h3C, "R11 hold without rd_en", rd_data, 8'h3C);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R11 all reads returned", sb_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule